// File: doc/BRIEF.md
# Host Packet-Command DMA Sequencer

This block is the host-side control sequencer for a packet command whose data phase uses DMA. After the command is issued, it waits the settle time and then polls the device status bits. It pushes the command packet out one data-register write per cycle. It then waits either for an interrupt or for a DMA request, depending on whether interrupts are masked. During the data phase it hands the bus to an external DMA engine. When the command finishes, it reports which follow-on state the host flow must enter next.

Both status-check states wait before their first status sample. The first wait covers the command settle time. The second covers one PIO cycle time, and it applies only when the state is entered from the packet send or the data phase. Both wait lengths are computed from the clock frequency. On every exit the block emits a single-cycle `done` pulse. An exit code and a copy of the error bit accompany it, and both hold until the next exit.

Top module: `pkt_dma_seq`

## Requirements
- R1: After reset, `busy`, `done`, `status_rd`, `data_wr` and `dma_enable` are 0, and `exit_code` and `err_flag` are 0.
- R2: In idle, a `start` pulse begins a command. The first `status_rd` comes after exactly ceil(CMD_WAIT_NS x CLK_MHZ / 1000) cycles, which is 100 at the default settings. While `st_bsy`=1, `status_rd` is asserted on every cycle and no exit is taken.
- R3: In the first status check, a sample with BSY=0 and DRQ=1 moves to packet send. A sample with BSY, DRQ, REL and SERV all 0 exits with code 0 (idle), whatever `queue_nonempty` is.
- R4: In packet send, `data_wr` is 1 on every cycle up to and including the cycle in which `pkt_last` is 1. After that cycle, `irq_off`=1 leads to the second status check. `irq_off`=0 leads to the interrupt wait, where `status_rd` stays 0.
- R5: The second status check samples for the first time after ceil(PIO_CYCLE_NS x CLK_MHZ / 1000) cycles (30 by default) when it is entered from packet send or the data phase. When it is entered from the interrupt wait, it samples in its first cycle.
- R6: In the second status check, a sample with BSY=0, DRQ=1, `dmarq`=1 and `irq_off`=1 enters the data phase. With `irq_off`=0, the same sample keeps the block polling.
- R7: In the second status check, a sample with BSY=0 and DRQ=0 exits with a 2-bit code, using this priority. SERV=1 gives 3 (service write). Otherwise, REL=1 or `queue_nonempty`=1 gives 1 (released-queue interrupt wait) if `irq_off`=0, or 2 (released-queue status check) if `irq_off`=1. Otherwise the code is 0 (idle).
- R8: In the interrupt wait, `dmarq`=1 enters the data phase regardless of `irq_off`. `intrq`=1 with `irq_off`=0 enters the second status check. `intrq` is ignored while `irq_off`=1.
- R9: `dma_enable` is 1 only in the data phase. In the data phase, `dma_done` with `irq_off`=1 returns to the second status check. `dma_done` with `irq_off`=0 goes to the interrupt wait. `dma_term` without `dma_done` returns to the second status check.
- R10: `done` is a one-cycle pulse in the cycle after the exiting status sample, and `busy` is 0 in that cycle. `exit_code`, and `err_flag` (the value of `st_err` at that sample), hold until the next exit.
- R11: `start` has no effect while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Packet command issued (pulse) |
| st_bsy | input | 1 | Device status: busy |
| st_drq | input | 1 | Device status: data request |
| st_rel | input | 1 | Device status: bus released |
| st_serv | input | 1 | Device status: service requested |
| st_err | input | 1 | Device status: error |
| intrq | input | 1 | Device interrupt request |
| dmarq | input | 1 | Device DMA request |
| irq_off | input | 1 | Device interrupts masked (1 = masked) |
| queue_nonempty | input | 1 | Device holds released queued commands |
| pkt_last | input | 1 | Current data-register write completes the packet |
| dma_done | input | 1 | DMA engine moved all data for the command |
| dma_term | input | 1 | DMA burst terminated |
| busy | output | 1 | Command in progress |
| status_rd | output | 1 | Status register read (sample) this cycle |
| data_wr | output | 1 | Packet word written to data register this cycle |
| dma_enable | output | 1 | DMA engine owns the data transfer |
| done | output | 1 | One-cycle exit pulse |
| exit_code | output | 2 | Follow-on state: 0 idle, 1 queue interrupt wait, 2 queue status check, 3 service |
| err_flag | output | 1 | Error bit seen at the last exit |

## Verification
The bench measures both settle waits to the exact cycle. A timer that is off by one, or that reloads when a polling loop repeats, shows up as a wrong sample count or as a sample taken too early after an interrupt. Random exits cover every mix of REL, SERV, queue and mask bits, so a wrong priority between SERV and REL, or a swapped mask polarity, returns a wrong code. Directed cases check three things. A DMA request with interrupts unmasked must not start the data phase from the status check. A masked interrupt must be ignored. A terminated burst and a completed burst must each return to the right state.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHKA  = 3'd1,
    S_SEND  = 3'd2,
    S_CHKB  = 3'd3,
    S_IWAIT = 3'd4,
    S_XFER  = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    X_IDLE    = 2'd0,
    X_QIRQ    = 2'd1,
    X_QSTAT   = 2'd2,
    X_SERVICE = 2'd3
  } exit_code_t;

  // Round a time in ns up to whole clock cycles.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Exit selection once BSY=0 and DRQ=0 in the second status check.
  function automatic exit_code_t late_exit(logic rel, logic serv, logic masked, logic q);
    if (serv)          return X_SERVICE;
    else if (rel || q) return masked ? X_QSTAT : X_QIRQ;
    else               return X_IDLE;
  endfunction

endpackage

// File: rtl/pkt_wait_timer.sv
module pkt_wait_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // Once run out, the timer stays run out until reloaded (R5).
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load |=> expired);

endmodule

// File: rtl/pkt_exit_decode.sv
module pkt_exit_decode
  import pkt_seq_pkg::*;
(
  input  logic       bsy,
  input  logic       drq,
  input  logic       rel,
  input  logic       serv,
  input  logic       masked,
  input  logic       queue_nonempty,
  input  logic       late_check,
  output logic       valid,
  output exit_code_t code
);

  logic quiet;

  always_comb begin
    quiet = !bsy && !drq;
    if (late_check) begin
      valid = quiet;
      code  = late_exit(rel, serv, masked, queue_nonempty);
    end else begin
      valid = quiet && !rel && !serv;
      code  = X_IDLE;
    end
  end

endmodule

// File: rtl/pkt_dma_seq.sv
module pkt_dma_seq
  import pkt_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 250,
  parameter int unsigned CMD_WAIT_NS  = 400,
  parameter int unsigned PIO_CYCLE_NS = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       st_bsy,
  input  logic       st_drq,
  input  logic       st_rel,
  input  logic       st_serv,
  input  logic       st_err,
  input  logic       intrq,
  input  logic       dmarq,
  input  logic       irq_off,
  input  logic       queue_nonempty,
  input  logic       pkt_last,
  input  logic       dma_done,
  input  logic       dma_term,
  output logic       busy,
  output logic       status_rd,
  output logic       data_wr,
  output logic       dma_enable,
  output logic       done,
  output logic [1:0] exit_code,
  output logic       err_flag
);

  localparam int unsigned WAIT_A = ns_to_cycles(CMD_WAIT_NS, CLK_MHZ);
  localparam int unsigned WAIT_B = ns_to_cycles(PIO_CYCLE_NS, CLK_MHZ);
  localparam int unsigned WMAX   = (WAIT_A > WAIT_B) ? WAIT_A : WAIT_B;
  localparam int unsigned CW     = $clog2(WMAX + 1);

  seq_state_t    st, st_nxt;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          in_check, sample, exit_now, x_valid;
  exit_code_t    x_code;

  pkt_wait_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
  );

  pkt_exit_decode u_exit (
    .bsy(st_bsy), .drq(st_drq), .rel(st_rel), .serv(st_serv),
    .masked(irq_off), .queue_nonempty(queue_nonempty),
    .late_check(st == S_CHKB), .valid(x_valid), .code(x_code)
  );

  assign in_check = (st == S_CHKA) || (st == S_CHKB);
  assign sample   = in_check && tmr_zero;
  assign exit_now = sample && x_valid;

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      S_IDLE: if (start) begin
        st_nxt = S_CHKA; tmr_load = 1'b1; tmr_val = CW'(WAIT_A);
      end
      S_CHKA: if (sample) begin
        if (!st_bsy && st_drq) st_nxt = S_SEND;
        else if (x_valid)      st_nxt = S_IDLE;
      end
      S_SEND: if (pkt_last) begin
        if (irq_off) begin
          st_nxt = S_CHKB; tmr_load = 1'b1; tmr_val = CW'(WAIT_B);
        end else begin
          st_nxt = S_IWAIT;
        end
      end
      S_CHKB: if (sample) begin
        if (!st_bsy && st_drq && dmarq && irq_off) st_nxt = S_XFER;
        else if (x_valid)                           st_nxt = S_IDLE;
      end
      S_IWAIT: begin
        if (dmarq) st_nxt = S_XFER;
        else if (intrq && !irq_off) begin
          st_nxt = S_CHKB; tmr_load = 1'b1; tmr_val = '0;
        end
      end
      S_XFER: begin
        if (dma_done) begin
          if (irq_off) begin
            st_nxt = S_CHKB; tmr_load = 1'b1; tmr_val = CW'(WAIT_B);
          end else begin
            st_nxt = S_IWAIT;
          end
        end else if (dma_term) begin
          st_nxt = S_CHKB; tmr_load = 1'b1; tmr_val = CW'(WAIT_B);
        end
      end
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      exit_code <= 2'd0;
      err_flag  <= 1'b0;
    end else begin
      st   <= st_nxt;
      done <= exit_now;
      if (exit_now) begin
        exit_code <= x_code;
        err_flag  <= st_err;
      end
    end
  end

  assign busy       = (st != S_IDLE);
  assign status_rd  = sample;
  assign data_wr    = (st == S_SEND);
  assign dma_enable = (st == S_XFER);

  p_first_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !status_rd);
  p_send_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !pkt_last |=> data_wr);
  p_dma_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_enable) |-> $past(dmarq));
  p_dma_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_enable |-> !data_wr && !status_rd);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(status_rd) && !busy);

endmodule

// File: tb/pkt_dma_seq_test.sv
module pkt_dma_seq_test;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, st_bsy = 0, st_drq = 0, st_rel = 0, st_serv = 0, st_err = 0;
  logic intrq = 0, dmarq = 0, irq_off = 0, queue_nonempty = 0, pkt_last = 0;
  logic dma_done = 0, dma_term = 0;
  logic busy, status_rd, data_wr, dma_enable, done, err_flag;
  logic [1:0] exit_code;

  int n_checks = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pkt_dma_seq uut (.*);

  // Expected wait lengths: 4 ns clock period.
  function automatic int wait_cycles(int ns);
    int c = 0;
    while (c * 4 < ns) c++;
    return c;
  endfunction

  function automatic int exp_code(bit masked, bit q, bit rel, bit serv);
    if (serv) return 3;
    if (!rel && !q) return 0;
    return masked ? 2 : 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_stat(bit b, bit d, bit r, bit s, bit e);
    st_bsy = b; st_drq = d; st_rel = r; st_serv = s; st_err = e;
  endtask

  task automatic count_to_sample(int exp, string req);
    int n = 0;
    while (!status_rd && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp, req, n, exp);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  // Issue command, pass first check into packet send.
  task automatic enter_send();
    set_stat(1, 0, 0, 0, 0);
    pulse_start();
    count_to_sample(wait_cycles(400), "R2 first wait");
    set_stat(0, 1, 0, 0, 0);
    @(negedge clk);
    chk(data_wr == 1, "R3 to send", data_wr, 1);
  endtask

  task automatic send_packet(int words);
    for (int i = 1; i <= words; i++) begin
      chk(data_wr == 1, "R4 word write", data_wr, 1);
      if (i == words) pkt_last = 1;
      @(negedge clk);
    end
    pkt_last = 0;
    set_stat(1, 0, 0, 0, 0);
    chk(data_wr == 0, "R4 send end", data_wr, 0);
  endtask

  task automatic expect_exit(int code, bit err, string req);
    @(negedge clk);
    chk(done == 1, {req, " done"}, done, 1);
    chk(exit_code == 2'(code), {req, " code"}, exit_code, code);
    chk(err_flag == err, "R10 err", err_flag, err);
    chk(busy == 0, "R10 idle", busy, 0);
    @(negedge clk);
    chk(done == 0, "R10 pulse", done, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && status_rd == 0, "R1 ctrl", busy, 0);
    chk(data_wr == 0 && dma_enable == 0, "R1 xfer", dma_enable, 0);
    chk(exit_code == 0 && err_flag == 0, "R1 code", exit_code, 0);
    rst_n = 1;

    // R2/R3: first check polls while busy, then idle exit with error
    set_stat(1, 0, 0, 0, 0);
    queue_nonempty = 1;
    pulse_start();
    count_to_sample(wait_cycles(400), "R2 wait");
    repeat (3) begin
      @(negedge clk);
      chk(status_rd == 1 && done == 0, "R2 poll", status_rd, 1);
    end
    set_stat(0, 0, 0, 0, 1);
    expect_exit(0, 1, "R3 idle exit");
    chk(exit_code == 0 && err_flag == 1, "R10 hold", err_flag, 1);
    queue_nonempty = 0;

    // Masked interrupts: status check, DMA, terminate, complete
    irq_off = 1;
    enter_send();
    send_packet(6);
    count_to_sample(wait_cycles(120), "R5 pio wait");
    set_stat(0, 1, 0, 0, 0); dmarq = 1;
    @(negedge clk);
    chk(dma_enable == 1, "R6 enter xfer", dma_enable, 1);
    start = 1;
    @(negedge clk); start = 0;
    chk(dma_enable == 1 && status_rd == 0, "R11 start ignored", dma_enable, 1);
    dma_term = 1;
    @(negedge clk); dma_term = 0;
    chk(dma_enable == 0, "R9 term leaves", dma_enable, 0);
    count_to_sample(wait_cycles(120), "R9 term to check");
    @(negedge clk);
    chk(dma_enable == 1, "R6 re-enter", dma_enable, 1);
    dmarq = 0; dma_done = 1;
    @(negedge clk); dma_done = 0;
    set_stat(1, 0, 0, 0, 0);
    count_to_sample(wait_cycles(120), "R9 done masked");
    set_stat(0, 0, 1, 1, 0);
    expect_exit(3, 0, "R7 serv over rel");

    // Unmasked interrupts
    irq_off = 0;
    enter_send();
    send_packet(1);
    repeat (4) begin
      @(negedge clk);
      chk(status_rd == 0 && busy == 1 && dma_enable == 0, "R4 irq wait", status_rd, 0);
    end
    irq_off = 1; intrq = 1;
    repeat (3) begin
      @(negedge clk);
      chk(status_rd == 0, "R8 masked intrq", status_rd, 0);
    end
    irq_off = 0;
    @(negedge clk); intrq = 0;
    count_to_sample(0, "R5 no wait after intrq");
    set_stat(0, 1, 0, 0, 0); dmarq = 1;
    @(negedge clk);
    chk(dma_enable == 0 && status_rd == 1, "R6 unmasked stays", dma_enable, 0);
    irq_off = 1;
    @(negedge clk);
    chk(dma_enable == 1, "R6 xfer", dma_enable, 1);
    irq_off = 0; dmarq = 0; dma_done = 1;
    @(negedge clk); dma_done = 0;
    chk(dma_enable == 0 && status_rd == 0 && busy == 1, "R9 done unmasked", dma_enable, 0);
    dmarq = 1;
    @(negedge clk); dmarq = 0;
    chk(dma_enable == 1, "R8 dmarq to xfer", dma_enable, 1);
    dma_done = 1;
    @(negedge clk); dma_done = 0;
    intrq = 1;
    @(negedge clk); intrq = 0;
    count_to_sample(0, "R8 intrq to check");
    set_stat(0, 0, 1, 0, 0);
    expect_exit(1, 0, "R7 release unmasked");

    // Random exits
    for (int it = 0; it < 40; it++) begin
      bit m, q, r, s, e;
      int w;
      m = 1'($urandom); q = 1'($urandom); r = 1'($urandom);
      s = 1'($urandom); e = 1'($urandom);
      w = 1 + int'($urandom % 4);
      irq_off = m;
      enter_send();
      send_packet(w);
      if (!m) begin
        intrq = 1;
        @(negedge clk); intrq = 0;
        count_to_sample(0, "R5 random intrq");
      end else begin
        count_to_sample(wait_cycles(120), "R5 random pio");
      end
      queue_nonempty = q;
      set_stat(0, 0, r, s, e);
      expect_exit(exp_code(m, q, r, s), e, "R7 random");
      queue_nonempty = 0;
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule